// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Byte Queues

This block is a small asynchronous serial port that a processor drives through four word-addressed registers. Bytes the software writes are queued and sent out on a single line. Bytes that arrive on the receive line are queued until the software reads them. Each direction has its own 16-entry byte queue. The line format is fixed: one low start bit, eight data bits sent least significant bit first, no parity and one high stop bit. Every bit lasts `CLKS_PER_BIT` clock cycles. With a 50 MHz clock and a 115200 baud target, the default is 434.

The register port never stalls. A request is accepted in the cycle where `bus_req` is high, and read data appears one cycle later with `bus_rvalid`. Back-pressure is not signalled on the bus; software reads it from the status register. The transmit side is valid/ready in spirit: the serializer takes a byte only when its queue holds one and it is idle. A write that finds the transmit queue full is refused and lost. On the receive side there is no way to hold the line off. A byte that arrives while the receive queue is full is lost, and the loss is recorded as an overrun error.

The status register reports queue levels, the interrupt enable and the sticky line errors. Reading it clears those errors. A single interrupt line gives one-cycle pulses when data becomes available or when transmission drains the transmit queue.

Top module: `mm_uart`

## Requirements
- R1: Each direction buffers up to 16 bytes. Status bit1 is set while the receive queue holds 16 bytes, and status bit3 is set while the transmit queue holds 16 bytes.
- R2: Register words. Word 0 read returns the oldest received byte in bits 7:0 and removes it (reads 0 when the queue is empty). Word 1 write queues bits 7:0 for sending. Word 2 read returns status. Word 3 write is control. Status bit0 is set when the receive queue is non-empty, and bit2 is set when the transmit queue is empty.
- R3: A word 1 write while the transmit queue is full is dropped, and the queued bytes are unchanged.
- R4: A byte that completes while the receive queue is full is discarded and sets status bit5 (overrun).
- R5: A low level at the stop-bit centre sets status bit6 (framing). The byte is still queued. Status bit7 always reads 0.
- R6: A status read returns the error bits and then clears bits 5 and 6. The next status read shows them clear unless a new error has occurred.
- R7: Control write: bit0 empties the transmit queue, bit1 empties the receive queue, and bit4 sets the interrupt enable, which reads back as status bit4.
- R8: The transmit line idles high. Each frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit, each held for `CLKS_PER_BIT` cycles.
- R9: The receiver confirms a falling edge at half a bit time. A low pulse shorter than that queues nothing.
- R10: When the interrupt enable is set, `irq` pulses for one cycle after the receive queue goes from empty to non-empty, and after the serializer takes the last byte from the transmit queue. With the enable clear, `irq` stays low.
- R11: After reset the status reads 0x04, `txd` is high and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | BUS_W | Write data, bits 7:0 significant |
| bus_rdata | output | BUS_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench writes 18 bytes in a burst with the transmit line looped back. This fills the transmit queue, so one write must be dropped, and it overfills the receive queue, so one arriving byte must be lost. A design that let a write overwrite a queued byte, or that wrapped its receive queue, would return the wrong byte sequence or fail to flag the overrun. A hand-built frame with a low stop bit and a two-cycle low glitch check the receiver. A design that ignored the stop level would miss the framing error, and one that trusted the raw edge would queue a phantom byte. The bench also decodes the transmit line on its own, which catches an MSB-first or mistimed serializer that loopback alone would hide. Finally it counts interrupt pulses with the enable set and clear, which catches level-held or ungated interrupts.

// File: rtl/mm_uart_pkg.sv
package mm_uart_pkg;
  typedef enum logic [1:0] {
    REG_RXDATA = 2'd0,
    REG_TXDATA = 2'd1,
    REG_STATUS = 2'd2,
    REG_CTRL   = 2'd3
  } reg_addr_e;

  localparam int ST_RX_AVAIL = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;
  localparam int ST_IE       = 4;
  localparam int ST_OVERRUN  = 5;
  localparam int ST_FRAMING  = 6;
  localparam int ST_PARITY   = 7;

  localparam int CT_TX_FLUSH = 0;
  localparam int CT_RX_FLUSH = 1;
  localparam int CT_IE       = 4;

  localparam int DATA_BITS   = 8;
  localparam int FRAME_BITS  = DATA_BITS + 2;
endpackage

// File: rtl/mm_uart_fifo.sv
module mm_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/mm_uart_tx.sv
module mm_uart_tx
  import mm_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  localparam int CNTW = $clog2(CLKS_PER_BIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_empty,
  input  logic [DATA_BITS-1:0] src_data,
  output logic                 src_pop,
  output logic                 txd,
  output logic                 busy
);
  logic [FRAME_BITS-1:0] shreg;
  logic [CNTW-1:0]       cnt;
  logic [3:0]            nbit;

  assign src_pop = !busy && !src_empty;
  assign txd     = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      busy  <= 1'b0;
      cnt   <= '0;
      nbit  <= '0;
    end else if (src_pop) begin
      shreg <= {1'b1, src_data, 1'b0};
      busy  <= 1'b1;
      cnt   <= '0;
      nbit  <= '0;
    end else if (busy) begin
      if (cnt == CNTW'(CLKS_PER_BIT - 1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (nbit == 4'(FRAME_BITS - 1)) busy <= 1'b0;
        else nbit <= nbit + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_uart_rx.sv
module mm_uart_rx
  import mm_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  localparam int CNTW = $clog2(CLKS_PER_BIT + 1),
  localparam int HALF = CLKS_PER_BIT / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 stop_bad
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  rx_state_e       state;
  logic            sync1, sync2, prev;
  logic [CNTW-1:0] cnt;
  logic [2:0]      nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1    <= 1'b1;
      sync2    <= 1'b1;
      prev     <= 1'b1;
      state    <= RX_IDLE;
      cnt      <= '0;
      nbit     <= '0;
      data     <= '0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      prev  <= sync2;
      done  <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (prev && !sync2) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CNTW'(HALF - 1)) begin
            cnt   <= '0;
            nbit  <= '0;
            state <= sync2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == CNTW'(CLKS_PER_BIT - 1)) begin
            cnt  <= '0;
            data <= {sync2, data[DATA_BITS-1:1]};
            if (nbit == 3'(DATA_BITS - 1)) state <= RX_STOP;
            else nbit <= nbit + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (cnt == CNTW'(CLKS_PER_BIT - 1)) begin
            done     <= 1'b1;
            stop_bad <= !sync2;
            state    <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mm_uart.sv
module mm_uart
  import mm_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int FIFO_DEPTH   = 16,
  parameter int BUS_W        = 32,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic             rxd,
  output logic             txd,
  output logic             irq
);
  logic                 wr_tx, rd_rx, rd_st, wr_ctl;
  logic                 flush_tx, flush_rx;
  logic                 ie_q, ovr_q, frm_q;
  logic [CW-1:0]        tx_count, rx_count;
  logic                 tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_BITS-1:0] tx_head, rx_head, rx_byte;
  logic                 tx_pop, tx_busy, rx_done, rx_stop_bad;
  logic                 rx_push_ok, tx_last_pop;
  logic [7:0]           status;

  assign wr_tx    = bus_req &&  bus_we && bus_addr == REG_TXDATA;
  assign rd_rx    = bus_req && !bus_we && bus_addr == REG_RXDATA;
  assign rd_st    = bus_req && !bus_we && bus_addr == REG_STATUS;
  assign wr_ctl   = bus_req &&  bus_we && bus_addr == REG_CTRL;
  assign flush_tx = wr_ctl && bus_wdata[CT_TX_FLUSH];
  assign flush_rx = wr_ctl && bus_wdata[CT_RX_FLUSH];

  mm_uart_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .flush(flush_tx), .push(wr_tx), .din(bus_wdata[DATA_BITS-1:0]),
    .pop(tx_pop), .dout(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full));

  mm_uart_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(flush_rx), .push(rx_done), .din(rx_byte),
    .pop(rd_rx), .dout(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full));

  mm_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_ser (
    .clk, .rst_n, .src_empty(tx_empty || flush_tx), .src_data(tx_head),
    .src_pop(tx_pop), .txd, .busy(tx_busy));

  mm_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_des (
    .clk, .rst_n, .rxd, .done(rx_done), .data(rx_byte), .stop_bad(rx_stop_bad));

  assign rx_push_ok  = rx_done && !rx_full && !flush_rx;
  assign tx_last_pop = tx_pop && tx_count == CW'(1) && !(wr_tx && !tx_full);

  always_comb begin
    status              = '0;
    status[ST_RX_AVAIL] = !rx_empty;
    status[ST_RX_FULL]  = rx_full;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_TX_FULL]  = tx_full;
    status[ST_IE]       = ie_q;
    status[ST_OVERRUN]  = ovr_q;
    status[ST_FRAMING]  = frm_q;
    status[ST_PARITY]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      ovr_q      <= 1'b0;
      frm_q      <= 1'b0;
      irq        <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (wr_ctl) ie_q <= bus_wdata[CT_IE];
      if (rx_done && rx_full)          ovr_q <= 1'b1;
      else if (rd_st)                  ovr_q <= 1'b0;
      if (rx_done && rx_stop_bad)      frm_q <= 1'b1;
      else if (rd_st)                  frm_q <= 1'b0;
      irq        <= ie_q && ((rx_push_ok && rx_empty) || tx_last_pop);
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        unique case (bus_addr)
          REG_RXDATA: bus_rdata <= rx_empty ? '0 : BUS_W'(rx_head);
          REG_STATUS: bus_rdata <= BUS_W'(status);
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mm_uart_checker.sv
module mm_uart_checker #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          txd,
  input logic          tx_busy,
  input logic          ie_q,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count
);
  assert_fifo_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  assert_tx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH)) |=> (tx_count <= CW'(DEPTH)) && (tx_count >= CW'(DEPTH - 1)) || (tx_count == '0));

  assert_txd_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie_q));

  assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0 && $past(rx_count) == '0 && $past(ie_q)) |-> irq);
endmodule

bind mm_uart mm_uart_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .txd(txd), .tx_busy(tx_busy),
  .ie_q(ie_q), .rx_count(rx_count), .tx_count(tx_count));

// File: tb/sim_mm_uart.sv
module sim_mm_uart;
  localparam int CPB = 8;
  localparam int NVEC = 6;
  // each entry: {byte sent over loopback, expected status after reception}
  localparam logic [NVEC*16-1:0] VEC = {
    8'h55, 8'h05, 8'hA3, 8'h05, 8'h00, 8'h05,
    8'hFF, 8'h05, 8'h81, 8'h05, 8'h7E, 8'h05};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        txd, irq;
  logic        loop_en = 1'b0;
  logic        rxd_drv = 1'b1;
  wire         rxd = loop_en ? txd : rxd_drv;
  int          total = 0, bad = 0, irq_cnt = 0;
  logic [7:0]  rd;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  mm_uart #(.CLKS_PER_BIT(CPB)) u0 (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_rvalid, .rxd, .txd, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = {24'h0, d};
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata[7:0];
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd_drv = f[i];
      wait_clk(CPB - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 txd", {31'h0, txd}, 32'h1);
    chk("R11 irq", {31'h0, irq}, 32'h0);
    bus_rd(2'd2, rd);
    chk("R11 status", {24'h0, rd}, 32'h04);

    // R2 R8 loopback vectors, interrupts off (R10: no pulses)
    loop_en = 1'b1;
    for (int i = NVEC - 1; i >= 0; i--) begin
      logic [7:0] stim, exps;
      stim = VEC[i*16+8 +: 8];
      exps = VEC[i*16 +: 8];
      bus_wr(2'd1, stim);
      wait_clk(12 * CPB);
      bus_rd(2'd2, rd);
      chk("R2 status after rx", {24'h0, rd}, {24'h0, exps});
      bus_rd(2'd0, rd);
      chk("R2 rx byte", {24'h0, rd}, {24'h0, stim});
    end
    chk("R10 no irq when disabled", irq_cnt, 0);
    bus_rd(2'd0, rd);
    chk("R2 empty read", {24'h0, rd}, 32'h0);

    // R8 independent decode of the transmit line
    loop_en = 1'b0;
    bus_wr(2'd1, 8'hA5);
    begin
      logic [7:0] got;
      logic       st;
      while (txd !== 1'b0) @(negedge clk);
      wait_clk(CPB / 2);
      chk("R8 start bit", {31'h0, txd}, 32'h0);
      for (int b = 0; b < 8; b++) begin
        wait_clk(CPB);
        got[b] = txd;
      end
      wait_clk(CPB);
      st = txd;
      chk("R8 lsb-first byte", {24'h0, got}, 32'hA5);
      chk("R8 stop bit", {31'h0, st}, 32'h1);
    end
    wait_clk(2 * CPB);

    // R1 R3 R4 R6: fill transmit queue, overfill receive queue
    loop_en = 1'b1;
    for (int i = 0; i < 18; i++) bus_wr(2'd1, 8'(i));
    bus_rd(2'd2, rd);
    chk("R1 R3 tx full", {24'h0, rd}, 32'h08);
    wait_clk(18 * 10 * CPB + 40);
    bus_rd(2'd2, rd);
    chk("R4 R1 overrun and rx full", {24'h0, rd}, 32'h27);
    bus_rd(2'd2, rd);
    chk("R6 errors cleared", {24'h0, rd}, 32'h07);
    begin
      int errs = 0;
      for (int i = 0; i < 16; i++) begin
        bus_rd(2'd0, rd);
        if (rd !== 8'(i)) errs++;
      end
      chk("R3 R4 byte order, dropped write and lost byte", errs, 0);
    end
    bus_rd(2'd2, rd);
    chk("R3 nothing left", {24'h0, rd}, 32'h04);

    // R10 interrupts enabled: two pulses for one byte
    bus_wr(2'd3, 8'h10);
    bus_rd(2'd2, rd);
    chk("R7 ie reads back", {24'h0, rd}, 32'h14);
    irq_cnt = 0;
    bus_wr(2'd1, 8'h3A);
    wait_clk(12 * CPB);
    chk("R10 pulse count", irq_cnt, 2);
    bus_rd(2'd0, rd);
    chk("R10 byte", {24'h0, rd}, 32'h3A);
    bus_wr(2'd3, 8'h00);

    // R5 framing error with low stop bit
    loop_en = 1'b0;
    drive_frame(8'h3C, 1'b0);
    wait_clk(CPB);
    @(negedge clk); rxd_drv = 1'b1;
    wait_clk(2 * CPB);
    bus_rd(2'd2, rd);
    chk("R5 framing set, parity 0", {24'h0, rd}, 32'h45);
    bus_rd(2'd0, rd);
    chk("R5 byte kept", {24'h0, rd}, 32'h3C);
    bus_rd(2'd2, rd);
    chk("R6 framing cleared", {24'h0, rd}, 32'h04);

    // R9 short glitch
    @(negedge clk); rxd_drv = 1'b0;
    wait_clk(2);
    rxd_drv = 1'b1;
    wait_clk(12 * CPB);
    bus_rd(2'd2, rd);
    chk("R9 glitch ignored", {24'h0, rd}, 32'h04);

    // R7 flushes
    for (int i = 0; i < 3; i++) bus_wr(2'd1, 8'h11);
    bus_rd(2'd2, rd);
    chk("R7 tx queued", {24'h0, rd}, 32'h00);
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd2, rd);
    chk("R7 tx flushed", {24'h0, rd}, 32'h04);
    wait_clk(12 * CPB);
    loop_en = 1'b1;
    bus_wr(2'd1, 8'h21);
    bus_wr(2'd1, 8'h22);
    wait_clk(24 * CPB);
    bus_rd(2'd2, rd);
    chk("R7 rx filled", {24'h0, rd}, 32'h05);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd2, rd);
    chk("R7 rx flushed", {24'h0, rd}, 32'h04);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule